// File: doc/BRIEF.md
# Dual-Halfword Exchange Saturating Adder

This block works on two 32-bit packed operands, N and M. Each operand holds two 16-bit halves. The block pairs each half of N with the opposite half of M, so the lanes are crossed. In one lane it adds, and in the other it subtracts. Each lane's result is clamped to the 16-bit range on its own, and the two results are packed into one 32-bit word. An order select picks which lane adds and which subtracts. A mode select picks whether the halves are treated as two's-complement or as unsigned values. The block has no overflow or sticky flag output, so saturation is visible only in the data.

Operands are presented with an input valid strobe. The result is registered and appears one cycle later with its own valid strobe. Between strobes the result word keeps its last value. A pipeline stage that already holds the two source words drives the block.

Top module: `hx_sat_unit`

## Requirements
- R1: With `in_order` = 0, the low lane is sat(N[15:0] − M[31:16]) and the high lane is sat(N[31:16] + M[15:0]).
- R2: With `in_order` = 1, the low lane is sat(N[15:0] + M[31:16]) and the high lane is sat(N[31:16] − M[15:0]).
- R3: With `in_unsigned` = 0, every half is sign-extended. Each lane result is clamped to −32768..32767 (0x8000..0x7FFF), and the arithmetic does not wrap before the clamp.
- R4: With `in_unsigned` = 1, every half is zero-extended. A negative lane result becomes 0x0000, and a lane result above 65535 becomes 0xFFFF.
- R5: The low-lane result is placed in `out_result[15:0]` and the high-lane result in `out_result[31:16]`.
- R6: The two lanes saturate independently. Clamping in one lane leaves the other lane's exact result unchanged.
- R7: A result for operands accepted on a clock edge where `in_valid` = 1 appears after that edge with `out_valid` = 1. `out_valid` is 0 after an edge where `in_valid` = 0.
- R8: After an edge where `in_valid` = 0, `out_result` keeps its previous value, whatever `in_n`, `in_m`, `in_order` and `in_unsigned` carry.
- R9: On a clock edge where `rst_n` = 0, `out_valid` and `out_result` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| in_unsigned | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| in_order | input | 1 | 0 = subtract low / add high, 1 = add low / subtract high |
| in_n | input | 32 | First packed operand |
| in_m | input | 32 | Second packed operand, halves crossed against N |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 32 | Packed saturated result |

## Verification
Small in-range operands, run under both orders, show which lane adds and which subtracts, and that each lane is packed into the correct half of the word. Signed operands at the extremes, such as 0x7FFF against 0x8000, drive one lane past the positive limit while the other goes past the negative limit or stays exact. This separates a proper clamp from a 16-bit wrap and shows that the lanes are independent. Unsigned operands with 0x8000 and 0xFFFF halves show that zero-extension is used rather than sign-extension, and that both the floor at 0 and the ceiling at 0xFFFF apply. A long back-to-back run of pseudo-random words in all four mode/order combinations is then checked, with idle gaps carrying garbage operands in between, to exercise result hold.

// File: rtl/xsat_pkg.sv
// Shared encodings for the dual-halfword exchange saturating adder.
// Assumes the order and mode selects are single bits supplied by decode.
package xsat_pkg;

    // Which lane subtracts; the opposite lane adds.
    typedef enum logic {
        ORD_SUBLO_ADDHI = 1'b0,
        ORD_ADDLO_SUBHI = 1'b1
    } xorder_e;

    // How each half is interpreted and which range it clamps to.
    typedef enum logic {
        MODE_SIGNED   = 1'b0,
        MODE_UNSIGNED = 1'b1
    } xmode_e;

endpackage

// File: rtl/xsat_clamp.sv
// Clamp a widened lane result to the HALF_W range selected by mode.
// Assumes the input carries two guard bits above HALF_W, so that it never
// wrapped when it was formed.
module xsat_clamp #(
    parameter int HALF_W = 16
) (
    input  logic signed [HALF_W+1:0] raw,
    input  xsat_pkg::xmode_e         mode,
    output logic        [HALF_W-1:0] sat
);
    localparam int EXT_W = HALF_W + 2;

    localparam logic signed [EXT_W-1:0] S_MAX = {3'b000, {(HALF_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] S_MIN = {3'b111, {(HALF_W-1){1'b0}}};
    localparam logic signed [EXT_W-1:0] U_MAX = {2'b00, {HALF_W{1'b1}}};
    localparam logic signed [EXT_W-1:0] U_MIN = '0;

    logic signed [EXT_W-1:0] hi_lim;
    logic signed [EXT_W-1:0] lo_lim;

    // Choose the limits that belong to the selected mode.
    always_comb begin
        if (mode == xsat_pkg::MODE_UNSIGNED) begin
            hi_lim = U_MAX;
            lo_lim = U_MIN;
        end else begin
            hi_lim = S_MAX;
            lo_lim = S_MIN;
        end
    end

    // Pin the raw value to the limits, then keep the low HALF_W bits.
    always_comb begin
        if (raw > hi_lim)
            sat = hi_lim[HALF_W-1:0];
        else if (raw < lo_lim)
            sat = lo_lim[HALF_W-1:0];
        else
            sat = raw[HALF_W-1:0];
    end

endmodule

// File: rtl/xsat_lane.sv
// One lane: widen both halves by the mode, add or subtract, then clamp.
// Assumes lhs comes from N and rhs from the crossed half of M.
module xsat_lane #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0] lhs,
    input  logic [HALF_W-1:0] rhs,
    input  logic              do_sub,
    input  xsat_pkg::xmode_e  mode,
    output logic [HALF_W-1:0] lane_out
);
    localparam int EXT_W = HALF_W + 2;

    logic signed [EXT_W-1:0] lhs_x;
    logic signed [EXT_W-1:0] rhs_x;
    logic signed [EXT_W-1:0] raw;

    // Widen both halves, with zero or sign extension set by the mode.
    always_comb begin
        if (mode == xsat_pkg::MODE_UNSIGNED) begin
            lhs_x = {2'b00, lhs};
            rhs_x = {2'b00, rhs};
        end else begin
            lhs_x = {{2{lhs[HALF_W-1]}}, lhs};
            rhs_x = {{2{rhs[HALF_W-1]}}, rhs};
        end
    end

    // Full-precision add or subtract; two guard bits prevent any wrap.
    always_comb begin
        if (do_sub)
            raw = lhs_x - rhs_x;
        else
            raw = lhs_x + rhs_x;
    end

    xsat_clamp #(.HALF_W(HALF_W)) u_clamp (
        .raw  (raw),
        .mode (mode),
        .sat  (lane_out)
    );

endmodule

// File: rtl/xsat_outreg.sv
// Result register with valid strobe; the data is loaded only on valid.
// Assumes a synchronous, active-low reset.
module xsat_outreg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] d,
    output logic              valid_q,
    output logic [WORD_W-1:0] q
);
    // Register the strobe every cycle, and the data only when loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            q       <= '0;
        end else begin
            valid_q <= load;
            if (load)
                q <= d;
        end
    end

endmodule

// File: rtl/hx_sat_unit.sv
// Dual-halfword exchange saturating adder. Lane 0 pairs N low with M high
// and lane 1 pairs N high with M low. in_order picks which lane subtracts,
// and each lane clamps on its own. The result is registered (1-cycle latency).
// Assumes the operands are stable on the edge where in_valid is 1.
module hx_sat_unit #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_unsigned,
    input  logic                in_order,
    input  logic [2*HALF_W-1:0] in_n,
    input  logic [2*HALF_W-1:0] in_m,
    output logic                out_valid,
    output logic [2*HALF_W-1:0] out_result
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int LANES  = 2;

    xsat_pkg::xmode_e  mode;
    xsat_pkg::xorder_e order;
    logic [WORD_W-1:0] packed_res;

    // Map the raw select pins onto the package encodings.
    always_comb begin
        mode  = xsat_pkg::xmode_e'(in_unsigned);
        order = xsat_pkg::xorder_e'(in_order);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [HALF_W-1:0] lhs;
        logic [HALF_W-1:0] rhs;
        logic              lane_sub;

        // Cross the halves and pick this lane's operation from the order.
        always_comb begin
            lhs = in_n[g*HALF_W +: HALF_W];
            rhs = in_m[(LANES-1-g)*HALF_W +: HALF_W];
            if (g == 0)
                lane_sub = (order == xsat_pkg::ORD_SUBLO_ADDHI);
            else
                lane_sub = (order == xsat_pkg::ORD_ADDLO_SUBHI);
        end

        xsat_lane #(.HALF_W(HALF_W)) u_lane (
            .lhs      (lhs),
            .rhs      (rhs),
            .do_sub   (lane_sub),
            .mode     (mode),
            .lane_out (packed_res[g*HALF_W +: HALF_W])
        );
    end

    xsat_outreg #(.WORD_W(WORD_W)) u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (packed_res),
        .valid_q (out_valid),
        .q       (out_result)
    );

endmodule

// File: rtl/xsat_chk.sv
// Protocol and corner-case checks for hx_sat_unit, bound to each instance.
module xsat_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_unsigned,
    input logic                in_order,
    input logic [2*HALF_W-1:0] in_n,
    input logic [2*HALF_W-1:0] in_m,
    input logic                out_valid,
    input logic [2*HALF_W-1:0] out_result
);
    localparam int WORD_W = 2 * HALF_W;

    // R9: reset clears strobe and data.
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0));

    // R7: an accepted operand pair yields a valid result next cycle.
    a_r7_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: no operands, no result strobe.
    a_r7_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: the result word holds while idle.
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    // R1: subtracting equal halves in the low lane gives zero.
    a_r1_self_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_order && in_n[HALF_W-1:0] == in_m[WORD_W-1:HALF_W])
        |=> out_result[HALF_W-1:0] == '0);

    // R4: an unsigned high-lane difference below zero floors at zero.
    a_r4_unsigned_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_unsigned && in_order && in_n[WORD_W-1:HALF_W] < in_m[HALF_W-1:0])
        |=> out_result[WORD_W-1:HALF_W] == '0);

endmodule

bind hx_sat_unit xsat_chk #(.HALF_W(HALF_W)) u_xsat_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_unsigned (in_unsigned),
    .in_order    (in_order),
    .in_n        (in_n),
    .in_m        (in_m),
    .out_valid   (out_valid),
    .out_result  (out_result)
);

// File: tb/test_hx_sat_unit.sv
// Scoreboard bench: the driver queues expected words, the monitor compares.
module test_hx_sat_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_unsigned = 1'b0;
    logic        in_order = 1'b0;
    logic [31:0] in_n = '0;
    logic [31:0] in_m = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int          checks = 0;
    int          errors = 0;
    bit          mon_en = 1'b0;
    bit          done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_res = '0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    hx_sat_unit i_hx_sat_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_unsigned (in_unsigned),
        .in_order    (in_order),
        .in_n        (in_n),
        .in_m        (in_m),
        .out_valid   (out_valid),
        .out_result  (out_result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference for one lane, written straight from the requirements.
    function automatic logic [15:0] ref_lane(logic [15:0] a, logic [15:0] b, bit sub, bit uns);
        int av, bv, r;
        av = uns ? int'(a) : int'($signed(a));
        bv = uns ? int'(b) : int'($signed(b));
        r  = sub ? av - bv : av + bv;
        if (uns) begin
            if (r < 0) r = 0;
            if (r > 65535) r = 65535;
        end else begin
            if (r < -32768) r = -32768;
            if (r > 32767) r = 32767;
        end
        return r[15:0];
    endfunction

    function automatic logic [31:0] ref_word(bit uns, bit ord, logic [31:0] n, logic [31:0] m);
        logic [15:0] lo, hi;
        lo = ref_lane(n[15:0], m[31:16], !ord, uns);
        hi = ref_lane(n[31:16], m[15:0], ord, uns);
        return {hi, lo};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: present one operand pair and queue its expected result.
    task automatic drive(bit uns, bit ord, logic [31:0] n, logic [31:0] m, string tag);
        @(negedge clk);
        in_valid    = 1'b1;
        in_unsigned = uns;
        in_order    = ord;
        in_n        = n;
        in_m        = m;
        exp_q.push_back(ref_word(uns, ord, n, m));
        tag_q.push_back(tag);
    endtask

    // Idle cycles with garbage on the operand pins (R8).
    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid    = 1'b0;
            lfsr        = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            in_n        = lfsr;
            in_m        = ~lfsr;
            in_unsigned = lfsr[3];
            in_order    = lfsr[7];
        end
    endtask

    // Monitor: just after each edge, pop and compare, or check the held value.
    always @(posedge clk) begin
        #1;
        if (mon_en && rst_n) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected strobe", {31'd0, out_valid}, 32'd0);
                end else begin
                    check(tag_q.pop_front(), out_result, exp_q.pop_front());
                end
                last_res = out_result;
            end else begin
                check("R8 hold", out_result, last_res);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset data", out_result, 32'd0);
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // R1 / R5: small values, subtract low, add high.
        drive(1'b0, 1'b0, 32'h0003_0005, 32'h0002_0001, "R1 R5 basic");
        // R2: same operands, add low, subtract high.
        drive(1'b0, 1'b1, 32'h0003_0005, 32'h0002_0001, "R2 basic");
        idle(2);
        // R3: low lane over the top, high lane under the bottom.
        drive(1'b0, 1'b0, 32'h8000_7FFF, 32'h8000_FFFF, "R3 both clamp");
        // R3: add-low sum that would wrap at 16 bits.
        drive(1'b0, 1'b1, 32'h0001_7FFF, 32'h7FFF_0002, "R3 no wrap");
        // R6: low lane clamps, high lane exact.
        drive(1'b0, 1'b0, 32'h0010_7FFF, 32'h8000_0005, "R6 independent");
        // R4: floor at zero in the low lane, ceiling in the high lane.
        drive(1'b1, 1'b0, 32'hFFFF_0001, 32'h0002_0001, "R4 floor ceiling");
        // R4: 0x8000 read as a positive value, no clamp.
        drive(1'b1, 1'b1, 32'h1000_8000, 32'h0001_0002, "R4 zero extend");
        // R4: high lane difference below zero.
        drive(1'b1, 1'b1, 32'h0001_0000, 32'h0000_0005, "R4 floor high");
        idle(3);

        // R7: back-to-back pseudo-random pairs over every mode and order.
        for (int k = 0; k < 60; k++) begin
            logic [31:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr ^ 32'h8001_7FFE;
            drive(k[0], k[1], a, b, k[1] ? "R2 R7 stream" : "R1 R7 stream");
            if (k % 13 == 12) idle(2);
        end
        idle(4);

        check("R7 drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule